// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block works out which serial NOR flash sits on an SPI port. It starts a probe on its own when reset is released, and again whenever `start_i` is pulsed while it is idle. A probe reads the JEDEC identification response. It skips any bank-continuation bytes and captures the manufacturer code, a 16-bit device ID and a 16-bit extended ID. It then classifies the part. Parts from one manufacturer carry their density in the status register, so the block reads that register and decodes a page size from it. For another manufacturer, the power-up write protection has to be lifted, so the block sends the sequence that clears it.

The byte-level SPI engine sits outside the block. The probe holds `cs_active_o` for the whole of a command frame. It presents one byte at a time on `byte_out_o` with `byte_req_o`, and it takes the byte received in return on `byte_in_i` when `byte_ack_i` pulses. Each frame ends with at least one cycle in which `cs_active_o` is low. The result shows on `done_o`, with a `valid_o` or `unknown_o` verdict, the identity bytes, a vendor class and the page-write length. A lookup table of known parts is a module parameter.

Top module: `flash_id_probe`

## Requirements
- R1: A probe starts by itself after reset is released. Its first frame sends 0x9F and then a 0x00 filler byte for each byte received. `cs_active_o` stays high for the whole frame and goes low between frames.
- R2: A received manufacturer byte of 0x7F is a continuation code and causes another byte to be read. Up to 8 consecutive continuation codes are accepted. A ninth one ends the frame with `unknown_o`.
- R3: After the manufacturer byte, exactly four more bytes are read, in this order: device ID high, device ID low, extended ID high, extended ID low. They appear on `dev_id_o` and `ext_id_o`, and the manufacturer byte appears on `mfr_o`.
- R4: Only the manufacturer codes 0x01, 0x20, 0xBF, 0x1F and 0xEF are recognised. Any other code gives `unknown_o`.
- R5: For codes 0x01, 0x20, 0xBF and 0xEF, a table entry matches when its manufacturer code and device ID are equal to the received ones, and its extended ID is either zero or equal to the received extended ID. If no entry matches, the result is `unknown_o`. The default table holds these parts (manufacturer/device/extended): 01/2018/0301, 01/2018/0300, 01/0216/0000, 20/2015/0000, BF/2502/0000 and EF/3013/0000.
- R6: For code 0x1F the block runs a second frame, [0xD7, 0x00], and captures the second received byte as the status. Status bits [5:2] select the page size: values 3, 5, 7 and 9 give 264 bytes, 11 and 13 give 528 bytes, and 15 gives 1056 bytes. Any other value gives `unknown_o`.
- R7: For code 0x1F, if status bit 0 is set, the lowest set bit of the page size is cleared (264→256, 528→512, 1056→1024).
- R8: `vclass_o` is 1 with `write_len_o` = 256 for codes 0x01, 0x20 and 0xEF. It is 2 with `write_len_o` = 1 for code 0xBF. It is 3 with `write_len_o` = the page size for code 0x1F. While `valid_o` is high, `write_len_o` is never zero.
- R9: After a successful match with code 0xBF, the block sends frame [0x06] and then frame [0x01, 0x00] before it reports done, so that a probe uses three frames in all.
- R10: A `start_i` pulse while `valid_o` is high raises `done_o` within 3 cycles with the result unchanged, and sends no bus traffic.
- R11: A `start_i` pulse after an unknown result runs a full new probe on the bus.
- R12: `done_o` is a one-cycle pulse, and `valid_o` and `unknown_o` are never high together. `byte_req_o` only occurs inside a frame and holds a stable byte until it is acknowledged. After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a probe (ignored while busy) |
| cs_active_o | output | 1 | Chip-select frame active |
| byte_req_o | output | 1 | Byte transfer requested from the SPI engine |
| byte_out_o | output | 8 | Byte to transmit |
| byte_ack_i | input | 1 | Engine finished the byte; `byte_in_i` valid |
| byte_in_i | input | 8 | Byte received during the transfer |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Part identified |
| unknown_o | output | 1 | Part not identified |
| mfr_o | output | 8 | Manufacturer code |
| dev_id_o | output | 16 | Device ID |
| ext_id_o | output | 16 | Extended device ID |
| vclass_o | output | 2 | Vendor class: 0 none, 1 paged, 2 byte-write, 3 status-density |
| write_len_o | output | 11 | Page-write length in bytes |

## Verification
The corners that are hardest to reach are the long continuation runs: exactly eight 0x7F bytes must still identify, while nine must abort. Density decoding is also hard to reach, because its result depends on a second frame. The bench's flash model serves a scripted ID stream with a chosen number of leading 0x7F bytes. It answers the density-status opcode with a chosen status byte, so each table vector fixes both the stream and the status. Cached and re-probe behaviour only shows up after a previous verdict exists. Those cases therefore run after a reset-started probe, and the bench checks that the model's byte log stays empty or fills again, as each case requires.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    localparam logic [7:0] OP_READ_ID   = 8'h9F;
    localparam logic [7:0] OP_DEN_STAT  = 8'hD7;
    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_WR_STAT   = 8'h01;
    localparam logic [7:0] BYTE_FILL    = 8'h00;
    localparam logic [7:0] CONT_CODE    = 8'h7F;

    localparam logic [7:0] MFR_PAGED_A  = 8'h01;
    localparam logic [7:0] MFR_PAGED_B  = 8'h20;
    localparam logic [7:0] MFR_PAGED_C  = 8'hEF;
    localparam logic [7:0] MFR_BYTEWR   = 8'hBF;
    localparam logic [7:0] MFR_DENSITY  = 8'h1F;

    localparam int PAGE_W = 11;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_PAGED   = 2'd1,
        CLS_BYTEWR  = 2'd2,
        CLS_DENSITY = 2'd3
    } vendor_cls_e;

    typedef struct packed {
        logic [7:0]  mfr;
        logic [15:0] dev;
        logic [15:0] ext;
    } part_id_t;

    localparam int DEF_NUM_PARTS = 6;
    localparam part_id_t [DEF_NUM_PARTS-1:0] DEF_PART_TABLE = '{
        '{mfr: 8'hEF, dev: 16'h3013, ext: 16'h0000},
        '{mfr: 8'hBF, dev: 16'h2502, ext: 16'h0000},
        '{mfr: 8'h20, dev: 16'h2015, ext: 16'h0000},
        '{mfr: 8'h01, dev: 16'h0216, ext: 16'h0000},
        '{mfr: 8'h01, dev: 16'h2018, ext: 16'h0300},
        '{mfr: 8'h01, dev: 16'h2018, ext: 16'h0301}
    };

    function automatic vendor_cls_e class_of(input logic [7:0] code);
        case (code)
            MFR_PAGED_A, MFR_PAGED_B, MFR_PAGED_C: return CLS_PAGED;
            MFR_BYTEWR:                            return CLS_BYTEWR;
            MFR_DENSITY:                           return CLS_DENSITY;
            default:                               return CLS_NONE;
        endcase
    endfunction

    function automatic logic [PAGE_W-1:0] density_page(input logic [3:0] code);
        case (code)
            4'd3, 4'd5, 4'd7, 4'd9: return PAGE_W'(264);
            4'd11, 4'd13:           return PAGE_W'(528);
            4'd15:                  return PAGE_W'(1056);
            default:                return '0;
        endcase
    endfunction

    function automatic logic [PAGE_W-1:0] drop_low_bit(input logic [PAGE_W-1:0] p);
        return p & (p - PAGE_W'(1));
    endfunction

endpackage

// File: rtl/flash_part_match.sv
module flash_part_match
    import flash_probe_pkg::*;
#(
    parameter int                          N_PARTS = DEF_NUM_PARTS,
    parameter part_id_t [N_PARTS-1:0]      PARTS   = DEF_PART_TABLE
) (
    input  part_id_t probe_id,
    output logic     hit
);
    logic [N_PARTS-1:0] entry_hit;

    for (genvar i = 0; i < N_PARTS; i++) begin : g_entry
        assign entry_hit[i] = (PARTS[i].mfr == probe_id.mfr) &&
                              (PARTS[i].dev == probe_id.dev) &&
                              ((PARTS[i].ext == 16'h0000) || (PARTS[i].ext == probe_id.ext));
    end

    assign hit = |entry_hit;
endmodule

// File: rtl/flash_density_decode.sv
module flash_density_decode
    import flash_probe_pkg::*;
(
    input  logic [7:0]        status,
    output logic              known,
    output logic [PAGE_W-1:0] page
);
    logic [PAGE_W-1:0] base_page;

    assign base_page = density_page(status[5:2]);
    assign known     = (base_page != '0);
    assign page      = status[0] ? drop_low_bit(base_page) : base_page;
endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
    import flash_probe_pkg::*;
#(
    parameter int MAX_CONT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              cs_active_o,
    output logic              byte_req_o,
    output logic [7:0]        byte_out_o,
    input  logic              byte_ack_i,
    input  logic [7:0]        byte_in_i,
    input  logic              tbl_hit_i,
    input  logic              den_known_i,
    input  logic [PAGE_W-1:0] den_page_i,
    output part_id_t          id_o,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              unknown_o,
    output vendor_cls_e       cls_o,
    output logic [PAGE_W-1:0] wlen_o
);
    localparam int CNT_W = $clog2(MAX_CONT + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_ID_OP, S_ID_MFR, S_ID_TAIL, S_GAP, S_CLASSIFY,
        S_DEN_OP, S_DEN_RD, S_DEN_EVAL, S_WREN, S_WRSR_OP, S_WRSR_VAL, S_FINISH
    } state_e;

    state_e            state, ret_state;
    logic [CNT_W-1:0]  cont_cnt;
    logic [1:0]        tail_cnt;
    part_id_t          id_q;
    logic [7:0]        status_q;
    logic              verdict_ok, valid_q, unknown_q, done_q, auto_pend;
    vendor_cls_e       cls_q, cls_now;
    logic [PAGE_W-1:0] wlen_q;
    logic              in_frame;

    always_comb begin
        case (state)
            S_ID_OP, S_ID_MFR, S_ID_TAIL, S_DEN_OP, S_DEN_RD,
            S_WREN, S_WRSR_OP, S_WRSR_VAL: in_frame = 1'b1;
            default:                       in_frame = 1'b0;
        endcase
    end

    always_comb begin
        case (state)
            S_ID_OP:   byte_out_o = OP_READ_ID;
            S_DEN_OP:  byte_out_o = OP_DEN_STAT;
            S_WREN:    byte_out_o = OP_WR_EN;
            S_WRSR_OP: byte_out_o = OP_WR_STAT;
            default:   byte_out_o = BYTE_FILL;
        endcase
    end

    assign cls_now     = class_of(id_q.mfr);
    assign cs_active_o = in_frame;
    assign byte_req_o  = in_frame;
    assign busy_o      = (state != S_IDLE);
    assign done_o      = done_q;
    assign valid_o     = valid_q;
    assign unknown_o   = unknown_q;
    assign id_o        = id_q;
    assign status_o    = status_q;
    assign cls_o       = cls_q;
    assign wlen_o      = wlen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            ret_state  <= S_IDLE;
            cont_cnt   <= '0;
            tail_cnt   <= '0;
            id_q       <= '0;
            status_q   <= '0;
            verdict_ok <= 1'b0;
            valid_q    <= 1'b0;
            unknown_q  <= 1'b0;
            done_q     <= 1'b0;
            auto_pend  <= 1'b1;
            cls_q      <= CLS_NONE;
            wlen_q     <= '0;
        end else begin
            done_q <= (state == S_FINISH);
            case (state)
                S_IDLE: begin
                    if (auto_pend || start_i) begin
                        auto_pend <= 1'b0;
                        if (valid_q) begin
                            state <= S_FINISH;
                        end else begin
                            unknown_q  <= 1'b0;
                            verdict_ok <= 1'b0;
                            cls_q      <= CLS_NONE;
                            wlen_q     <= '0;
                            id_q       <= '0;
                            status_q   <= '0;
                            cont_cnt   <= '0;
                            tail_cnt   <= '0;
                            state      <= S_ID_OP;
                        end
                    end
                end
                S_ID_OP: if (byte_ack_i) state <= S_ID_MFR;
                S_ID_MFR: begin
                    if (byte_ack_i) begin
                        if (byte_in_i == CONT_CODE) begin
                            if (cont_cnt == CNT_W'(MAX_CONT)) begin
                                verdict_ok <= 1'b0;
                                ret_state  <= S_FINISH;
                                state      <= S_GAP;
                            end else begin
                                cont_cnt <= cont_cnt + CNT_W'(1);
                            end
                        end else begin
                            id_q.mfr <= byte_in_i;
                            state    <= S_ID_TAIL;
                        end
                    end
                end
                S_ID_TAIL: begin
                    if (byte_ack_i) begin
                        tail_cnt <= tail_cnt + 2'd1;
                        case (tail_cnt)
                            2'd0: id_q.dev[15:8] <= byte_in_i;
                            2'd1: id_q.dev[7:0]  <= byte_in_i;
                            2'd2: id_q.ext[15:8] <= byte_in_i;
                            default: begin
                                id_q.ext[7:0] <= byte_in_i;
                                ret_state     <= S_CLASSIFY;
                                state         <= S_GAP;
                            end
                        endcase
                    end
                end
                S_GAP: state <= ret_state;
                S_CLASSIFY: begin
                    if (cls_now == CLS_DENSITY) begin
                        state <= S_DEN_OP;
                    end else if (cls_now != CLS_NONE && tbl_hit_i) begin
                        verdict_ok <= 1'b1;
                        cls_q      <= cls_now;
                        wlen_q     <= (cls_now == CLS_BYTEWR) ? PAGE_W'(1) : PAGE_W'(256);
                        state      <= (cls_now == CLS_BYTEWR) ? S_WREN : S_FINISH;
                    end else begin
                        verdict_ok <= 1'b0;
                        state      <= S_FINISH;
                    end
                end
                S_DEN_OP: if (byte_ack_i) state <= S_DEN_RD;
                S_DEN_RD: begin
                    if (byte_ack_i) begin
                        status_q  <= byte_in_i;
                        ret_state <= S_DEN_EVAL;
                        state     <= S_GAP;
                    end
                end
                S_DEN_EVAL: begin
                    verdict_ok <= den_known_i;
                    if (den_known_i) begin
                        cls_q  <= CLS_DENSITY;
                        wlen_q <= den_page_i;
                    end
                    state <= S_FINISH;
                end
                S_WREN: begin
                    if (byte_ack_i) begin
                        ret_state <= S_WRSR_OP;
                        state     <= S_GAP;
                    end
                end
                S_WRSR_OP: if (byte_ack_i) state <= S_WRSR_VAL;
                S_WRSR_VAL: begin
                    if (byte_ack_i) begin
                        ret_state <= S_FINISH;
                        state     <= S_GAP;
                    end
                end
                S_FINISH: begin
                    valid_q   <= verdict_ok;
                    unknown_q <= !verdict_ok;
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int                     MAX_CONT = 8,
    parameter int                     N_PARTS  = DEF_NUM_PARTS,
    parameter part_id_t [N_PARTS-1:0] PARTS    = DEF_PART_TABLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              cs_active_o,
    output logic              byte_req_o,
    output logic [7:0]        byte_out_o,
    input  logic              byte_ack_i,
    input  logic [7:0]        byte_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              unknown_o,
    output logic [7:0]        mfr_o,
    output logic [15:0]       dev_id_o,
    output logic [15:0]       ext_id_o,
    output logic [1:0]        vclass_o,
    output logic [PAGE_W-1:0] write_len_o
);
    part_id_t          id_w;
    logic [7:0]        status_w;
    logic              hit_w, den_known_w;
    logic [PAGE_W-1:0] den_page_w;
    vendor_cls_e       cls_w;

    flash_part_match #(.N_PARTS(N_PARTS), .PARTS(PARTS)) u_match (
        .probe_id (id_w),
        .hit      (hit_w)
    );

    flash_density_decode u_density (
        .status (status_w),
        .known  (den_known_w),
        .page   (den_page_w)
    );

    flash_probe_seq #(.MAX_CONT(MAX_CONT)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cs_active_o (cs_active_o),
        .byte_req_o  (byte_req_o),
        .byte_out_o  (byte_out_o),
        .byte_ack_i  (byte_ack_i),
        .byte_in_i   (byte_in_i),
        .tbl_hit_i   (hit_w),
        .den_known_i (den_known_w),
        .den_page_i  (den_page_w),
        .id_o        (id_w),
        .status_o    (status_w),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .valid_o     (valid_o),
        .unknown_o   (unknown_o),
        .cls_o       (cls_w),
        .wlen_o      (write_len_o)
    );

    assign mfr_o    = id_w.mfr;
    assign dev_id_o = id_w.dev;
    assign ext_id_o = id_w.ext;
    assign vclass_o = cls_w;
endmodule

// File: rtl/flash_probe_chk.sv
module flash_probe_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        cs_active_o,
    input logic        byte_req_o,
    input logic [7:0]  byte_out_o,
    input logic        byte_ack_i,
    input logic        done_o,
    input logic        valid_o,
    input logic        unknown_o,
    input logic [10:0] write_len_o
);
    // R12
    req_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        byte_req_o |-> cs_active_o);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R12
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && unknown_o));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_req_o && !byte_ack_i) |=> (byte_req_o && $stable(byte_out_o)));

    // R8
    wlen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (write_len_o != 11'd0));

    // R10
    cache_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && start_i) |=> !cs_active_o);
endmodule

bind flash_id_probe flash_probe_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cs_active_o (cs_active_o),
    .byte_req_o  (byte_req_o),
    .byte_out_o  (byte_out_o),
    .byte_ack_i  (byte_ack_i),
    .done_o      (done_o),
    .valid_o     (valid_o),
    .unknown_o   (unknown_o),
    .write_len_o (write_len_o)
);

// File: tb/flash_id_probe_tb.sv
module flash_id_probe_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        cs_active_o, byte_req_o, byte_ack_i = 1'b0;
    logic [7:0]  byte_out_o, byte_in_i = 8'h00;
    logic        busy_o, done_o, valid_o, unknown_o;
    logic [7:0]  mfr_o;
    logic [15:0] dev_id_o, ext_id_o;
    logic [1:0]  vclass_o;
    logic [10:0] write_len_o;

    always #4 clk = ~clk;

    flash_id_probe u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cs_active_o(cs_active_o), .byte_req_o(byte_req_o), .byte_out_o(byte_out_o),
        .byte_ack_i(byte_ack_i), .byte_in_i(byte_in_i),
        .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .unknown_o(unknown_o),
        .mfr_o(mfr_o), .dev_id_o(dev_id_o), .ext_id_o(ext_id_o),
        .vclass_o(vclass_o), .write_len_o(write_len_o)
    );

    typedef struct packed {
        int          cont;
        logic [7:0]  mfr;
        logic [15:0] dev;
        logic [15:0] ext;
        logic [7:0]  st;
        logic        ok;
        logic [1:0]  cls;
        logic [10:0] wlen;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{0, 8'h01, 16'h2018, 16'h0301, 8'h00, 1'b1, 2'd1, 11'd256},
        '{0, 8'h01, 16'h2018, 16'h0300, 8'h00, 1'b1, 2'd1, 11'd256},
        '{0, 8'h01, 16'h2018, 16'h0302, 8'h00, 1'b0, 2'd0, 11'd0},
        '{0, 8'h20, 16'h2015, 16'hABCD, 8'h00, 1'b1, 2'd1, 11'd256},
        '{0, 8'hEF, 16'h3013, 16'h0000, 8'h00, 1'b1, 2'd1, 11'd256},
        '{0, 8'hBF, 16'h2502, 16'h0000, 8'h00, 1'b1, 2'd2, 11'd1},
        '{0, 8'h1F, 16'h2400, 16'h0000, 8'h0C, 1'b1, 2'd3, 11'd264},
        '{0, 8'h1F, 16'h2400, 16'h0000, 8'h2D, 1'b1, 2'd3, 11'd512},
        '{0, 8'h1F, 16'h2400, 16'h0000, 8'h3C, 1'b1, 2'd3, 11'd1056},
        '{0, 8'h1F, 16'h2400, 16'h0000, 8'h3D, 1'b1, 2'd3, 11'd1024},
        '{0, 8'h1F, 16'h2400, 16'h0000, 8'h04, 1'b0, 2'd0, 11'd0},
        '{0, 8'hC2, 16'h2015, 16'h0000, 8'h00, 1'b0, 2'd0, 11'd0},
        '{8, 8'h20, 16'h2015, 16'h0000, 8'h00, 1'b1, 2'd1, 11'd256},
        '{9, 8'h20, 16'h2015, 16'h0000, 8'h00, 1'b0, 2'd0, 11'd0},
        '{2, 8'hEF, 16'h3013, 16'h0000, 8'h00, 1'b1, 2'd1, 11'd256}
    };

    // flash model state
    vec_t       mdl;
    logic [7:0] blog [64];
    int         nlog = 0;
    int         nframes = 0;
    int         checks = 0;
    int         errors = 0;

    function automatic logic [7:0] id_byte(input vec_t v, input int k);
        if (k < v.cont)          return 8'h7F;
        else if (k == v.cont)    return v.mfr;
        else if (k == v.cont+1)  return v.dev[15:8];
        else if (k == v.cont+2)  return v.dev[7:0];
        else if (k == v.cont+3)  return v.ext[15:8];
        else if (k == v.cont+4)  return v.ext[7:0];
        return 8'h00;
    endfunction

    initial begin
        int         pos;
        logic [7:0] op;
        logic       prev_cs;
        pos = 0; op = 8'h00; prev_cs = 1'b0;
        forever begin
            @(negedge clk);
            byte_ack_i = 1'b0;
            if (cs_active_o && !prev_cs) nframes++;
            prev_cs = cs_active_o;
            if (!cs_active_o) begin
                pos = 0;
            end else if (byte_req_o) begin
                if (nlog < 64) blog[nlog] = byte_out_o;
                nlog++;
                if (pos == 0) op = byte_out_o;
                if (pos > 0 && op == 8'h9F)      byte_in_i = id_byte(mdl, pos - 1);
                else if (pos == 1 && op == 8'hD7) byte_in_i = mdl.st;
                else                              byte_in_i = 8'h00;
                pos++;
                byte_ack_i = 1'b1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done never seen actual=0 expected=1");
        end
    endtask

    task automatic clear_log();
        nlog = 0;
        nframes = 0;
    endtask

    task automatic run_reset_probe(input vec_t v);
        int cyc;
        mdl = v;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clear_log();
        rst = 1'b0;
        wait_done(cyc);
    endtask

    initial begin
        int cyc;
        mdl = VECS[0];
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset valid", valid_o, 0);
        check("R12 reset unknown", unknown_o, 0);
        check("R12 reset done", done_o, 0);
        check("R12 reset cs", cs_active_o, 0);
        check("R12 reset req", byte_req_o, 0);

        for (int i = 0; i < NV; i++) begin
            run_reset_probe(VECS[i]);
            check("R2 R4 R5 R6 verdict valid", valid_o, VECS[i].ok);
            check("R2 R4 R5 R6 verdict unknown", unknown_o, !VECS[i].ok);
            if (VECS[i].ok) begin
                check("R8 vclass", vclass_o, VECS[i].cls);
                check("R7 R8 write_len", write_len_o, VECS[i].wlen);
            end
            if (VECS[i].cont <= 8) begin
                check("R3 mfr", mfr_o, VECS[i].mfr);
                check("R3 dev_id", dev_id_o, VECS[i].dev);
                check("R3 ext_id", ext_id_o, VECS[i].ext);
            end else begin
                check("R2 bytes before abort", nlog, 10);
            end
            if (i == 0) begin
                check("R1 byte count", nlog, 6);
                check("R1 opcode", blog[0], 8'h9F);
                for (int k = 1; k < 6; k++) check("R1 filler", blog[k], 8'h00);
                check("R1 one frame", nframes, 1);
            end
            if (i == 5) begin
                check("R9 byte count", nlog, 9);
                check("R9 write enable", blog[6], 8'h06);
                check("R9 status write op", blog[7], 8'h01);
                check("R9 status write value", blog[8], 8'h00);
                check("R9 frames", nframes, 3);
            end
            if (i == 6) begin
                check("R6 byte count", nlog, 8);
                check("R6 status opcode", blog[6], 8'hD7);
                check("R6 frames", nframes, 2);
            end
            if (i == 12) check("R2 eight continuations", nlog, 14);
            @(negedge clk);
            check("R12 done one cycle", done_o, 0);
        end

        // R10 cached result: last vector was valid
        clear_log();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(cyc);
        check("R10 cached latency", (cyc <= 3) ? 1 : 0, 1);
        check("R10 no bus bytes", nlog, 0);
        check("R10 still valid", valid_o, 1);
        check("R10 write_len kept", write_len_o, 256);
        @(negedge clk);

        // R11 re-probe after unknown
        run_reset_probe(VECS[11]);
        check("R11 first unknown", unknown_o, 1);
        @(negedge clk);
        clear_log();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(cyc);
        check("R11 bus bytes", nlog, 6);
        check("R11 unknown again", unknown_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule